// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block is a read-only cache that sits between a processor's word-read port and a slower backing memory that delivers one 32-bit word per handshake. It holds 16 KB of data as 1024 lines of four words. Each line keeps one tag and one valid bit. A byte address maps to exactly one line, so each lookup compares a single stored tag.

Each accepted read ends in one of three ways. The line can be valid with a matching tag, which is a hit. The line can be empty, which is a cold miss. The line can hold a different block, which is a conflict miss that evicts it. On either kind of miss, the controller fetches the whole four-word block, lowest word first, and writes the new tag. It then answers the pending read. A one-cycle flag reports which of the three outcomes occurred. The processor holds `req` for one cycle and waits for `ready`. While a lookup or refill is in progress, new requests are dropped.

Top module: `dm_read_cache`

## Requirements
- R1: After reset, every line is empty, and `ready`, `hit`, `miss`, `miss_replace` and `mem_req` are low until a request is accepted.
- R2: The address splits as tag = addr[31:14], line index = addr[13:4], word select = addr[3:2]. Bits [1:0] have no effect on which word is returned.
- R3: A request accepted at a clock edge to a valid line with an equal tag raises `ready` and `hit` in the following cycle and makes no memory read.
- R4: A request to an invalid line makes four memory reads and then completes with `miss` high.
- R5: A request to a valid line with a different tag makes four memory reads, replaces the tag, and completes with `miss_replace` high. The evicted block misses on its next access.
- R6: A refill drives `mem_addr` = {addr[31:4], w, 2'b00} for w = 0, 1, 2, 3 in that order. Each address is held until `mem_ack` is seen.
- R7: Whenever `ready` is high, `rdata` equals the backing-memory word at addr with bits [1:0] cleared, whether the access hit or missed.
- R8: `ready` is high for exactly one cycle per accepted request, together with exactly one of `hit`, `miss`, `miss_replace`. None of the three flags is high without `ready`.
- R9: `req` is ignored while a lookup or refill is in progress. Such a request produces no `ready`, no memory read, and no change to the line it addresses.
- R10: `ready` stays low while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Read request, accepted only when idle |
| addr | input | 32 | Byte address of the read |
| ready | output | 1 | Read complete, rdata valid this cycle |
| rdata | output | 32 | Returned word |
| hit | output | 1 | Outcome: hit |
| miss | output | 1 | Outcome: miss into an empty line |
| miss_replace | output | 1 | Outcome: miss that evicted a valid line |
| mem_req | output | 1 | Backing-memory word read request |
| mem_addr | output | 32 | Word-aligned backing-memory address |
| mem_ack | input | 1 | Backing memory has mem_rdata for mem_addr |
| mem_rdata | input | 32 | Backing-memory read data |

## Verification
Corrupt internal state shows up at the ports within one access.

- A valid bit stuck high or a stale tag turns an expected miss into a hit. That hit appears in the cycle right after the request, with the wrong `rdata` and zero memory reads.
- A valid bit that is never set, or a tag that is written incorrectly, makes a repeat access miss again. That repeat then shows four extra fetches.
- A wrong lane written during refill shows up as a data mismatch on a later hit to the same line.
- A refill counter that skips or reorders words is caught on the fetch addresses as they are issued.
- A controller that accepts requests while busy produces an unexpected `ready` or fetch within a few cycles.

// File: rtl/dm_cache_pkg.sv
// Shared types for the direct-mapped read cache.
// Assumes: none beyond the user of these types.
package dm_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL,
        ST_DONE
    } ctl_state_t;

    typedef enum logic {
        KIND_COLD,
        KIND_EVICT
    } miss_kind_t;
endpackage

// File: rtl/dm_tag_store.sv
// Per-line valid bits and tags.
// Valid bits clear on reset. Tags are not reset because they are only meaningful when valid.
// One combinational read port and one write port, which sets valid together with the tag.
module dm_tag_store #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid bits: clear all on reset, set on line install.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // Tag array write.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    // Read port for the indexed line.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end
endmodule

// File: rtl/dm_data_store.sv
// Line data held as one word-wide array per word lane.
// A refill writes one lane at a time. The read port returns the selected word of a line.
// Assumes the write lane and index are stable for the cycle of the write.
module dm_data_store #(
    parameter int IDX_W  = 10,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic [IDX_W-1:0]         idx,
    input  logic [$clog2(WORDS)-1:0] rd_word,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_word,
    input  logic [DATA_W-1:0]        wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [WORDS-1:0][DATA_W-1:0] line_words;

    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        logic [DATA_W-1:0] lane_q [LINES];

        // Lane write during refill when this lane is selected.
        always_ff @(posedge clk) begin
            if (wr_en && wr_word == w) lane_q[idx] <= wr_data;
        end

        // Lane read of the indexed line.
        always_comb line_words[w] = lane_q[idx];
    end

    // Word select for the returned data.
    always_comb rd_data = line_words[rd_word];
endmodule

// File: rtl/dm_ctl.sv
// Access controller.
// Takes one request when idle, judges it in the following cycle, and runs a refill of WORDS
// sequential memory reads on a miss. It then presents the result for one cycle.
// Assumes line_valid and tag_eq refer to the latched address.
module dm_ctl
    import dm_cache_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     line_valid,
    input  logic                     tag_eq,
    input  logic                     mem_ack,
    output logic                     accept,
    output logic                     ready,
    output logic                     hit,
    output logic                     miss,
    output logic                     miss_replace,
    output logic                     mem_req,
    output logic [$clog2(WORDS)-1:0] fill_word,
    output logic                     fill_we,
    output logic                     tag_we
);
    localparam int WSEL_W = $clog2(WORDS);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

    ctl_state_t        state_q;
    miss_kind_t        kind_q;
    logic [WSEL_W-1:0] cnt_q;
    logic              is_hit;
    logic              last_ack;

    // Outcome of the lookup and end-of-refill detection.
    always_comb begin
        is_hit   = line_valid && tag_eq;
        last_ack = (state_q == ST_FILL) && mem_ack && (cnt_q == LAST_WORD);
    end

    // State, miss kind and refill word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_COLD;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req) state_q <= ST_LOOK;
                ST_LOOK: begin
                    if (is_hit) begin
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_FILL;
                        kind_q  <= line_valid ? KIND_EVICT : KIND_COLD;
                        cnt_q   <= '0;
                    end
                end
                ST_FILL: begin
                    if (last_ack)     state_q <= ST_DONE;
                    else if (mem_ack) cnt_q   <= cnt_q + 1'b1;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded outputs.
    always_comb begin
        accept       = (state_q == ST_IDLE) && req;
        mem_req      = (state_q == ST_FILL);
        fill_word    = cnt_q;
        fill_we      = mem_req && mem_ack;
        tag_we       = last_ack;
        hit          = (state_q == ST_LOOK) && is_hit;
        miss         = (state_q == ST_DONE) && (kind_q == KIND_COLD);
        miss_replace = (state_q == ST_DONE) && (kind_q == KIND_EVICT);
        ready        = hit || (state_q == ST_DONE);
    end

    // R10: no completion while the memory side is busy.
    a_r10_quiet_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ready);

    // R6: a fill word is held until acknowledged.
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(fill_word)));

    // R9: a request arriving while busy is not accepted.
    a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !accept);
endmodule

// File: rtl/dm_read_cache.sv
// Direct-mapped, read-only cache top.
// Latches the request address and looks up one line. On a miss it refills the line from a
// word-wide backing memory, then returns the addressed word with a one-cycle outcome flag.
// Assumes the backing memory returns data with mem_ack for the address held on mem_addr.
module dm_read_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              hit,
    output logic              miss,
    output logic              miss_replace,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic [ADDR_W-1:0] a_q;
    logic              accept;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic              tag_eq;
    logic [WSEL_W-1:0] fill_word;
    logic              fill_we;
    logic              tag_we;
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_word;

    // Latch the address of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)      a_q <= '0;
        else if (accept) a_q <= addr;
    end

    // Address field split and tag compare.
    always_comb begin
        a_tag    = a_q[ADDR_W-1 -: TAG_W];
        a_idx    = a_q[OFF_W +: IDX_W];
        a_word   = a_q[BYTE_W +: WSEL_W];
        tag_eq   = (line_tag == a_tag);
        mem_addr = {a_q[ADDR_W-1:OFF_W], fill_word, {BYTE_W{1'b0}}};
    end

    dm_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (a_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .wr_en    (tag_we),
        .wr_idx   (a_idx),
        .wr_tag   (a_tag)
    );

    dm_data_store #(.IDX_W(IDX_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .idx     (a_idx),
        .rd_word (a_word),
        .rd_data (rdata),
        .wr_en   (fill_we),
        .wr_word (fill_word),
        .wr_data (mem_rdata)
    );

    dm_ctl #(.WORDS(WORDS)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .line_valid   (line_valid),
        .tag_eq       (tag_eq),
        .mem_ack      (mem_ack),
        .accept       (accept),
        .ready        (ready),
        .hit          (hit),
        .miss         (miss),
        .miss_replace (miss_replace),
        .mem_req      (mem_req),
        .fill_word    (fill_word),
        .fill_we      (fill_we),
        .tag_we       (tag_we)
    );

    // R8: exactly one outcome flag accompanies each completion.
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $onehot({hit, miss, miss_replace}));

    // R8: no outcome flag without a completion.
    a_r8_flag_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || miss || miss_replace) |-> ready);

    // R8: a completion lasts one cycle.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R4/R5: after a refill the line is valid and holds the new tag.
    a_r5_line_installed: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |=> (line_valid && tag_eq));

    // R6: fetch addresses are word aligned.
    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[BYTE_W-1:0] == '0));

    // R1: the outputs are quiet right after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !(ready || mem_req));
endmodule

// File: tb/sim_dm_read_cache.sv
module sim_dm_read_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic        ready, hit, miss, miss_replace, mem_req;
    logic [31:0] rdata, mem_addr, mem_rdata;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int fails = 0;
    int fetches = 0;
    int fetch_base = 0;
    int ord_err = 0;
    logic [27:0] cur_blk = '0;

    always #10 clk = ~clk;   // 50 MHz

    dm_read_cache u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
        .ready(ready), .rdata(rdata), .hit(hit), .miss(miss),
        .miss_replace(miss_replace), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    // Backing memory: acknowledges every other cycle while requested.
    always @(posedge clk) mem_ack <= mem_req && !mem_ack;
    assign mem_rdata = mdata(mem_addr);

    // Fetch monitor: block and word order checked on every accepted word (R6).
    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_addr !== {cur_blk, 2'(fetches - fetch_base), 2'b00}) ord_err++;
            fetches++;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // kind: 0 hit, 1 cold miss, 2 evicting miss
    task automatic do_read(input logic [31:0] a, input int kind, input bit poke_busy);
        int waited;
        int e0;
        e0 = ord_err;
        fetch_base = fetches;
        cur_blk = a[31:4];
        @(negedge clk);
        req = 1'b1;
        addr = a;
        @(negedge clk);
        req = 1'b0;
        waited = 0;
        while (!ready && waited < 40) begin
            if (poke_busy) begin
                req = 1'b1;
                addr = 32'h0000_6004;
            end
            check(!ready || !mem_req, "R10", 32'(ready), 0);
            @(negedge clk);
            req = 1'b0;
            waited++;
        end
        check(ready === 1'b1, "R8 ready", 32'(ready), 1);
        check(rdata === mdata(a), "R7 data", rdata, mdata(a));
        check({hit, miss, miss_replace} === (kind == 0 ? 3'b100 : kind == 1 ? 3'b010 : 3'b001),
              kind == 0 ? "R3 hit" : kind == 1 ? "R4 miss" : "R5 replace",
              {29'b0, hit, miss, miss_replace}, 32'(kind));
        check((fetches - fetch_base) == (kind == 0 ? 0 : 4), "R6 fetch count",
              32'(fetches - fetch_base), kind == 0 ? 0 : 4);
        check(ord_err == e0, "R6 order", 32'(ord_err - e0), 0);
        if (kind == 0) check(waited == 0, "R3 latency", 32'(waited), 0);
        @(negedge clk);
        check(!ready, "R8 single", 32'(ready), 0);
    endtask

    localparam int NV = 10;
    localparam logic [33:0] VEC [NV] = '{
        {32'h0000_0014, 2'd1},   // R4 cold, line 1
        {32'h0000_001C, 2'd0},   // R3 hit, word 3
        {32'h0000_0034, 2'd1},   // R4 cold, line 3
        {32'h0000_8014, 2'd2},   // R5 tag 2 evicts line 1
        {32'h0000_0030, 2'd0},   // R3 hit
        {32'h0000_001C, 2'd2},   // R5 evicted block misses again
        {32'h0000_0017, 2'd0},   // R2 bits [1:0] ignored
        {32'h0003_FFF0, 2'd1},   // R2 last line
        {32'hFFFF_FFFC, 2'd2},   // R5 all-ones tag
        {32'h0003_FFF8, 2'd2}    // R5 back again
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({ready, hit, miss, miss_replace, mem_req} === 5'b0, "R1 reset outputs",
              {27'b0, ready, hit, miss, miss_replace, mem_req}, 0);

        for (int i = 0; i < NV; i++) do_read(VEC[i][33:2], int'(VEC[i][1:0]), 1'b0);

        // R9: requests during a refill are dropped.
        do_read(32'h0000_5000, 1, 1'b1);
        for (int i = 0; i < 6; i++) begin
            check(!ready && !mem_req, "R9 no late action",
                  {30'b0, ready, mem_req}, 0);
            @(negedge clk);
        end
        do_read(32'h0000_6004, 1, 1'b0);   // R9 line untouched by the dropped request
        do_read(32'h0000_5000, 0, 1'b0);

        // R1: reset empties every line.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(32'h0000_0030, 1, 1'b0);
        do_read(32'h0000_0034, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule